// File: doc/BRIEF.md
# Memory Interface Power-Up Sequencer

This block brings a high-speed memory interface out of reset without software help. Once `start` is seen, it walks a fixed order of steps. It sets the current-drive control, waits for calibration to settle, and strobes the new current value into the interface cell for one clock. It then turns on the receive and transmit paths and holds the attached devices in reset for a fixed time. Last, it moves the interface into normal standby operation with idle powerdown enabled and raises `init_done`.

The outputs are the same control lines a register writer would otherwise drive. A static input picks the current-control flavour. With it high, automatic calibration is used. With it low, the sequencer falls back to a fixed manual drive value. Both wait windows are parameters.

Top module: `phy_bringup_seq`

## Requirements
- R1: While reset is active and in the idle state afterwards, `rx_sel` and `tx_sel` are 0, `cc_load`, `cc_auto_en` and `init_done` are 0, `cc_value` is 0, `op_mode` is 2'b00, and `stop_tx`, `stop_rx` and `pwr_up` are 1.
- R2: On the first clock edge that sees `start` high in idle, the current control is set. With `auto_cal`=1 the outputs are `cc_value`=6'h00 and `cc_auto_en`=1. With `auto_cal`=0 they are `cc_value`=6'h10 and `cc_auto_en`=0. This setting then holds until the next reset.
- R3: `cc_load` goes high exactly CAL_WAIT clock cycles (default 4096) after the current control is set.
- R4: `cc_load` is high for exactly one clock cycle, once per sequence.
- R5: The cycle after the load strobe, `rx_sel` becomes 4 and `tx_sel` becomes 1. Both keep these values afterwards.
- R6: The cycle after the selects are set, `op_mode` is 2'b00 (device reset) and both `stop_tx` and `stop_rx` are 0. This state lasts exactly RST_HOLD cycles (default 100).
- R7: The hold is followed by the final step. In it, `op_mode` becomes 2'b10 (standby) and both stop bits return to 1, which gives the 4-bit value {stop_rx, stop_tx, op_mode} = 4'hE.
- R8: `init_done` rises one cycle after the final step and stays high until the next reset.
- R9: A `start` pulse while the sequence is running, or after it has finished, has no effect on any output or on the step timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins the sequence when idle |
| auto_cal | input | 1 | Static: 1 selects automatic current calibration, 0 the manual fallback |
| cc_value | output | 6 | Manual current-drive value |
| cc_auto_en | output | 1 | Automatic current-control enable |
| cc_load | output | 1 | One-cycle strobe that loads the current value |
| rx_sel | output | 3 | Receive path select |
| tx_sel | output | 3 | Transmit path select |
| op_mode | output | 2 | Operating mode: 00 reset, 10 standby |
| stop_tx | output | 1 | Transmit idle-powerdown enable |
| stop_rx | output | 1 | Receive idle-powerdown enable |
| pwr_up | output | 1 | Interface power-up, held high |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench measures the exact cycle of each step against a count taken from the edge that accepted `start`. An off-by-one in either wait counter would move the load strobe or shorten the device-reset window, and either one shows up as a wrong index or length. Both calibration flavours are run. A swapped drive value or enable would show up as a wrong `cc_value`. Spurious `start` pulses are injected during the calibration wait, during the device-reset hold and after completion. A design that restarted on them would pulse `cc_load` twice or shift every later step.

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq #(
  parameter int CAL_WAIT = 4096,
  parameter int RST_HOLD = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       auto_cal,
  output logic [5:0] cc_value,
  output logic       cc_auto_en,
  output logic       cc_load,
  output logic [2:0] rx_sel,
  output logic [2:0] tx_sel,
  output logic [1:0] op_mode,
  output logic       stop_tx,
  output logic       stop_rx,
  output logic       pwr_up,
  output logic       init_done
);
  localparam int MAXW = (CAL_WAIT > RST_HOLD) ? CAL_WAIT : RST_HOLD;
  localparam int CW   = $clog2(MAXW) + 1;
  localparam logic [CW-1:0] CAL_LAST  = CW'(CAL_WAIT - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(RST_HOLD - 1);
  localparam logic [5:0] MANUAL_CC = 6'h10;

  typedef enum logic [2:0] {S_IDLE, S_CAL, S_LOAD, S_SEL, S_HOLD, S_FIN, S_DONE} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic          stop_q;

  assign pwr_up  = 1'b1;
  assign stop_tx = stop_q;
  assign stop_rx = stop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      cc_value   <= '0;
      cc_auto_en <= 1'b0;
      cc_load    <= 1'b0;
      rx_sel     <= '0;
      tx_sel     <= '0;
      op_mode    <= 2'b00;
      stop_q     <= 1'b1;
      init_done  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cc_value   <= auto_cal ? 6'h00 : MANUAL_CC;
          cc_auto_en <= auto_cal;
          cnt        <= '0;
          st         <= S_CAL;
        end
        S_CAL: begin
          if (cnt == CAL_LAST) begin
            cc_load <= 1'b1;
            st      <= S_LOAD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LOAD: begin
          cc_load <= 1'b0;
          rx_sel  <= 3'd4;
          tx_sel  <= 3'd1;
          st      <= S_SEL;
        end
        S_SEL: begin
          op_mode <= 2'b00;
          stop_q  <= 1'b0;
          cnt     <= '0;
          st      <= S_HOLD;
        end
        S_HOLD: begin
          if (cnt == HOLD_LAST) begin
            op_mode <= 2'b10;
            stop_q  <= 1'b1;
            st      <= S_FIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FIN: begin
          init_done <= 1'b1;
          st        <= S_DONE;
        end
        default: st <= S_DONE;
      endcase
    end
  end

  // R4
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_load |=> !cc_load);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_load |-> (cc_auto_en == auto_cal) && (cc_value == (auto_cal ? 6'h00 : MANUAL_CC)));

  // R6
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_tx |-> (rx_sel == 3'd4) && (tx_sel == 3'd1) && (op_mode == 2'b00));

  // R7
  done_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (op_mode == 2'b10) && stop_tx && stop_rx);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R5
  sel_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cc_load) |-> (rx_sel == 3'd4) && (tx_sel == 3'd1) && stop_tx);
endmodule

// File: tb/test_phy_bringup_seq.sv
module test_phy_bringup_seq;
  localparam int CAL_WAIT = 4096;
  localparam int RST_HOLD = 100;
  localparam int N_RUN    = CAL_WAIT + RST_HOLD + 120;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, auto_cal = 1'b0;
  logic [5:0] cc_value;
  logic cc_auto_en, cc_load, stop_tx, stop_rx, pwr_up, init_done;
  logic [2:0] rx_sel, tx_sel;
  logic [1:0] op_mode;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  phy_bringup_seq #(.CAL_WAIT(CAL_WAIT), .RST_HOLD(RST_HOLD)) i_phy_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .auto_cal(auto_cal),
    .cc_value(cc_value), .cc_auto_en(cc_auto_en), .cc_load(cc_load),
    .rx_sel(rx_sel), .tx_sel(tx_sel), .op_mode(op_mode),
    .stop_tx(stop_tx), .stop_rx(stop_rx), .pwr_up(pwr_up), .init_done(init_done));

  // {auto_cal, glitch sample index (0 = none)}
  localparam logic [13:0] VEC [4] = '{
    {1'b1, 13'd0},
    {1'b0, 13'd0},
    {1'b1, 13'd2000},
    {1'b0, 13'd4150}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_idle(input string req);
    chk(req, {26'd0, cc_value}, 0);
    chk(req, {cc_auto_en, cc_load, init_done}, 0);
    chk(req, {rx_sel, tx_sel, op_mode}, 0);
    chk(req, {stop_tx, stop_rx, pwr_up}, 3'b111);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 during reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_idle("R1 in reset");
    do_reset();
    repeat (5) @(negedge clk);
    check_idle("R1 idle after reset");

    for (int v = 0; v < 4; v++) begin
      int first_load, load_cnt, first_sel, first_low, low_cnt, first_stby, first_done;
      int cc_bad, done_drop;
      logic exp_auto;
      int glitch;
      exp_auto = VEC[v][13];
      glitch   = int'(VEC[v][12:0]);
      auto_cal = exp_auto;
      do_reset();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      first_load = -1; load_cnt = 0; first_sel = -1; first_low = -1;
      low_cnt = 0; first_stby = -1; first_done = -1; cc_bad = 0; done_drop = 0;
      for (int n = 0; n < N_RUN; n++) begin
        if (cc_value != (exp_auto ? 6'h00 : 6'h10) || cc_auto_en != exp_auto) cc_bad++;
        if (cc_load) begin
          load_cnt++;
          if (first_load < 0) first_load = n;
        end
        if (first_sel < 0 && rx_sel == 3'd4 && tx_sel == 3'd1) first_sel = n;
        if (!stop_tx || !stop_rx) begin
          low_cnt++;
          if (first_low < 0) first_low = n;
        end
        if (first_stby < 0 && op_mode == 2'b10) first_stby = n;
        if (init_done && first_done < 0) first_done = n;
        if (first_done >= 0 && !init_done) done_drop++;
        if (glitch != 0 && n == glitch) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      chk("R2 current control value/enable", cc_bad, 0);
      chk("R3 load strobe index", first_load, CAL_WAIT);
      chk("R4 load strobe width", load_cnt, 1);
      chk("R5 selects index", first_sel, CAL_WAIT + 1);
      chk("R6 stop low index", first_low, CAL_WAIT + 2);
      chk("R6 stop low length", low_cnt, RST_HOLD);
      chk("R7 standby index", first_stby, CAL_WAIT + 2 + RST_HOLD);
      chk("R7 final word", {stop_rx, stop_tx, op_mode}, 4'hE);
      chk("R8 init_done index", first_done, CAL_WAIT + 3 + RST_HOLD);
      chk("R8 init_done sticky", done_drop, 0);
      if (glitch != 0) chk("R9 glitch start ignored", load_cnt, 1);
    end

    // R9: start after completion changes nothing
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) begin
      chk("R9 post-done load", {31'd0, cc_load}, 0);
      @(negedge clk);
    end
    chk("R9 post-done outputs", {rx_sel, tx_sel, op_mode, stop_tx, stop_rx, init_done}, {3'd4, 3'd1, 2'b10, 3'b111});

    // R1 reset clears a finished sequence
    do_reset();
    check_idle("R1 reset after done");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule